// File: doc/BRIEF.md
# Scoreboard Issue and Operand Controller

This block is the central bookkeeping for a pipeline that issues instructions in program order but lets them read operands, execute and finish out of order. It tracks five functional units: two floating-point multipliers, one floating-point adder, one floating-point divider and one integer unit. It does not forward values. Instead it holds a status record for each unit and a table that names, for each architectural register, the unit that will produce its next value. From these it decides when each step may proceed.

Each cycle the front end presents one decoded instruction: its unit class, destination register and two source registers. The controller answers with an accept flag and the index of the unit it picked. The front end holds a refused instruction and presents it again, so nothing behind it can go first. The units report the end of execution on `exec_done`. The controller returns one-hot grants: one that tells a unit to read its registers and start, and one that lets a finished unit write its result. Datapaths and register contents live outside the block.

Top module: `sb_ctrl`

## Requirements
- R1: An instruction is accepted (`issue_ok` high in the same cycle as `in_valid`) only if a unit of its class is idle and no active instruction targets its destination register. It goes to the lowest-indexed idle unit of that class, and `issue_unit` reports that index.
- R2: While a structural or write-after-write hazard persists, `issue_ok` stays low for the held instruction. It rises in the first cycle the hazard is gone.
- R3: A unit receives `rd_grant` only after issue and only when no active instruction is still due to write either of its sources.
- R4: At most one `rd_grant` bit and one `wr_grant` bit are high in any cycle. When several units are eligible, the lowest unit index wins.
- R5: `exec_done` for a unit moves it to result-pending only while it is executing. At any other time the bit is ignored.
- R6: A finished unit is denied `wr_grant` while another unit that has not yet read its operands holds the finished unit's destination as a ready, unread source.
- R7: A write grant frees the unit and clears its destination's table entry at that edge. Units waiting on that producer see their source as ready. An instruction issued in that same cycle that names the register also sees it as ready.
- R8: After reset, every unit is idle, no register is pending and all grants are low.
- R9: The class codes are 0 multiply, 1 add, 2 divide and 3 integer. The unit indices are 0 and 1 for the multipliers, 2 for the adder, 3 for the divider and 4 for the integer unit. Bit n of each grant vector and of `exec_done` belongs to unit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 2 | Unit class of the instruction |
| in_dst | input | 5 | Destination register |
| in_sa | input | 5 | First source register |
| in_sb | input | 5 | Second source register |
| exec_done | input | 5 | Per-unit end of execution |
| issue_ok | output | 1 | Instruction accepted this cycle |
| issue_unit | output | 3 | Index of the accepting unit |
| rd_grant | output | 5 | One-hot operand-read grant |
| wr_grant | output | 5 | One-hot result-write grant |

## Verification
The bench holds instructions against a busy integer unit and against a pending destination register. A design that ignored either hazard would raise the accept flag too early. It builds a case where a finished adder must wait for a divider that has not yet read the adder's destination register. A design without that check would grant the write at once and destroy the divider's operand. Another case issues an instruction in the same cycle its source's producer writes back. A design that missed this would never grant that instruction a read. The bench also pulses `exec_done` for an idle unit, makes two finished units compete for the write grant, and resets the block in the middle of work.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    CLS_MUL = 2'd0,
    CLS_ADD = 2'd1,
    CLS_DIV = 2'd2,
    CLS_INT = 2'd3
  } fu_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_RD = 2'd1,
    ST_EXEC    = 2'd2,
    ST_WAIT_WB = 2'd3
  } slot_st_e;

  // Units are laid out multipliers first, then adders, dividers, integer.
  function automatic fu_cls_e unit_cls(int u, int n_mul, int n_add, int n_div);
    if (u < n_mul)                     return CLS_MUL;
    else if (u < n_mul + n_add)        return CLS_ADD;
    else if (u < n_mul + n_add + n_div) return CLS_DIV;
    else                               return CLS_INT;
  endfunction

endpackage

// File: rtl/sb_prio_arb.sv
module sb_prio_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // Lowest set bit wins.
  always_comb begin
    gnt = req & (~req + N'(1));
  end
endmodule

// File: rtl/sb_issue_check.sv
module sb_issue_check #(
  parameter int NU = 5
) (
  input  logic               in_valid,
  input  logic [1:0]         in_cls,
  input  logic [NU-1:0][1:0] cls_map,
  input  logic [NU-1:0]      unit_busy,
  input  logic               dst_pending,
  output logic               issue_ok,
  output logic [NU-1:0]      issue_sel
);
  logic [NU-1:0] cand;
  logic [NU-1:0] pick;

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      cand[u] = !unit_busy[u] && (cls_map[u] == in_cls);
    end
  end

  sb_prio_arb #(.N(NU)) u_pick (
    .req (cand),
    .gnt (pick)
  );

  always_comb begin
    issue_ok  = in_valid && (|cand) && !dst_pending;
    issue_sel = issue_ok ? pick : '0;
  end
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int RW = 5,
  parameter int UW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_sel,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_sa,
  input  logic [RW-1:0] in_sb,
  input  logic          pa_busy,
  input  logic [UW-1:0] pa_unit,
  input  logic          pb_busy,
  input  logic [UW-1:0] pb_unit,
  input  logic          wb_valid,
  input  logic [UW-1:0] wb_idx,
  input  logic          rd_gnt,
  input  logic          wr_gnt,
  input  logic          exec_done,
  output logic          busy,
  output logic          rd_req,
  output logic          wb_req,
  output logic [RW-1:0] dst,
  output logic [RW-1:0] sa,
  output logic [RW-1:0] sb,
  output logic          ra,
  output logic          rb
);
  slot_st_e      state_q, state_d;
  logic          ra_q, ra_d, rb_q, rb_d;
  logic [RW-1:0] dst_q, sa_q, sb_q;
  logic [UW-1:0] qa_q, qb_q;

  always_comb begin
    state_d = state_q;
    ra_d    = ra_q;
    rb_d    = rb_q;
    unique case (state_q)
      ST_IDLE: begin
        if (issue_sel) begin
          state_d = ST_WAIT_RD;
          ra_d    = !pa_busy || (wb_valid && pa_unit == wb_idx);
          rb_d    = !pb_busy || (wb_valid && pb_unit == wb_idx);
        end
      end
      ST_WAIT_RD: begin
        if (!ra_q && wb_valid && qa_q == wb_idx) ra_d = 1'b1;
        if (!rb_q && wb_valid && qb_q == wb_idx) rb_d = 1'b1;
        if (rd_gnt) begin
          state_d = ST_EXEC;
          ra_d    = 1'b0;
          rb_d    = 1'b0;
        end
      end
      ST_EXEC: begin
        if (exec_done) state_d = ST_WAIT_WB;
      end
      ST_WAIT_WB: begin
        if (wr_gnt) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ra_q    <= 1'b0;
      rb_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ra_q    <= ra_d;
      rb_q    <= rb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      sa_q  <= '0;
      sb_q  <= '0;
      qa_q  <= '0;
      qb_q  <= '0;
    end else if (issue_sel) begin
      dst_q <= in_dst;
      sa_q  <= in_sa;
      sb_q  <= in_sb;
      qa_q  <= pa_unit;
      qb_q  <= pb_unit;
    end
  end

  always_comb begin
    busy   = (state_q != ST_IDLE);
    rd_req = (state_q == ST_WAIT_RD) && ra_q && rb_q;
    wb_req = (state_q == ST_WAIT_WB);
    dst    = dst_q;
    sa     = sa_q;
    sb     = sb_q;
    ra     = ra_q && (state_q == ST_WAIT_RD);
    rb     = rb_q && (state_q == ST_WAIT_RD);
  end

  a_r1_issue_into_idle: assert property (@(posedge clk) disable iff (!rst_n)
    issue_sel |-> state_q == ST_IDLE);

  a_r3_read_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt |-> (state_q == ST_WAIT_RD && ra_q && rb_q));

  a_r5_done_on_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && state_q == ST_IDLE && !issue_sel) |=> state_q == ST_IDLE);

  a_r7_write_frees_unit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gnt |=> state_q == ST_IDLE);

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int N_MUL   = 2,
  parameter int N_ADD   = 1,
  parameter int N_DIV   = 1,
  parameter int N_INT   = 1,
  parameter int N_REGS  = 32,
  localparam int NU     = N_MUL + N_ADD + N_DIV + N_INT,
  localparam int UW     = (NU > 1) ? $clog2(NU) : 1,
  localparam int RW     = $clog2(N_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_cls,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_sa,
  input  logic [RW-1:0] in_sb,
  input  logic [NU-1:0] exec_done,
  output logic          issue_ok,
  output logic [UW-1:0] issue_unit,
  output logic [NU-1:0] rd_grant,
  output logic [NU-1:0] wr_grant
);
  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Result-status table.
  logic [N_REGS-1:0] rs_busy_q, rs_busy_d;
  logic [UW-1:0]     rs_unit_q [N_REGS];
  logic [UW-1:0]     rs_unit_d [N_REGS];

  logic [NU-1:0][1:0] cls_map;
  logic [NU-1:0]      slot_busy, slot_rd_req, slot_wb_req, slot_ra, slot_rb;
  logic [RW-1:0]      slot_dst [NU];
  logic [RW-1:0]      slot_sa  [NU];
  logic [RW-1:0]      slot_sb  [NU];
  logic [NU-1:0]      issue_sel, war_block, wb_elig;
  logic               wb_valid;
  logic [UW-1:0]      wb_idx;
  logic [RW-1:0]      wb_dst;

  for (genvar u = 0; u < NU; u++) begin : g_map
    assign cls_map[u] = unit_cls(u, N_MUL, N_ADD, N_DIV);
  end

  sb_issue_check #(.NU(NU)) u_issue (
    .in_valid    (in_valid),
    .in_cls      (in_cls),
    .cls_map     (cls_map),
    .unit_busy   (slot_busy),
    .dst_pending (rs_busy_q[in_dst]),
    .issue_ok    (issue_ok),
    .issue_sel   (issue_sel)
  );

  for (genvar u = 0; u < NU; u++) begin : g_slot
    sb_unit_slot #(.RW(RW), .UW(UW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .issue_sel (issue_sel[u]),
      .in_dst    (in_dst),
      .in_sa     (in_sa),
      .in_sb     (in_sb),
      .pa_busy   (rs_busy_q[in_sa]),
      .pa_unit   (rs_unit_q[in_sa]),
      .pb_busy   (rs_busy_q[in_sb]),
      .pb_unit   (rs_unit_q[in_sb]),
      .wb_valid  (wb_valid),
      .wb_idx    (wb_idx),
      .rd_gnt    (rd_grant[u]),
      .wr_gnt    (wr_grant[u]),
      .exec_done (exec_done[u]),
      .busy      (slot_busy[u]),
      .rd_req    (slot_rd_req[u]),
      .wb_req    (slot_wb_req[u]),
      .dst       (slot_dst[u]),
      .sa        (slot_sa[u]),
      .sb        (slot_sb[u]),
      .ra        (slot_ra[u]),
      .rb        (slot_rb[u])
    );
  end

  // Write-after-read guard: hold a result while someone still must read
  // the old value of its destination.
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      war_block[u] = 1'b0;
      for (int f = 0; f < NU; f++) begin
        if (f != u &&
            ((slot_ra[f] && slot_sa[f] == slot_dst[u]) ||
             (slot_rb[f] && slot_sb[f] == slot_dst[u])))
          war_block[u] = 1'b1;
      end
      wb_elig[u] = slot_wb_req[u] && !war_block[u];
    end
  end

  sb_prio_arb #(.N(NU)) u_rd_arb (
    .req (slot_rd_req),
    .gnt (rd_grant)
  );

  sb_prio_arb #(.N(NU)) u_wr_arb (
    .req (wb_elig),
    .gnt (wr_grant)
  );

  always_comb begin
    wb_idx     = '0;
    issue_unit = '0;
    for (int u = 0; u < NU; u++) begin
      if (wr_grant[u])  wb_idx     = UW'(u);
      if (issue_sel[u]) issue_unit = UW'(u);
    end
    wb_valid = |wr_grant;
    wb_dst   = slot_dst[wb_idx];
  end

  always_comb begin
    rs_busy_d = rs_busy_q;
    for (int r = 0; r < N_REGS; r++) rs_unit_d[r] = rs_unit_q[r];
    if (wb_valid) rs_busy_d[wb_dst] = 1'b0;
    if (issue_ok) begin
      rs_busy_d[in_dst] = 1'b1;
      rs_unit_d[in_dst] = issue_unit;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rs_busy_q <= '0;
      for (int r = 0; r < N_REGS; r++) rs_unit_q[r] <= '0;
    end else begin
      rs_busy_q <= rs_busy_d;
      for (int r = 0; r < N_REGS; r++) rs_unit_q[r] <= rs_unit_d[r];
    end
  end

  a_r4_read_onehot: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(rd_grant));

  a_r4_write_onehot: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(wr_grant));

  a_r1_no_waw_issue: assert property (@(posedge clk) disable iff (!rst_core_n)
    issue_ok |-> !rs_busy_q[in_dst]);

  a_r7_entry_cleared: assert property (@(posedge clk) disable iff (!rst_core_n)
    wb_valid |=> !rs_busy_q[$past(wb_dst)]);

  a_r8_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (slot_busy == '0 && rs_busy_q == '0));

endmodule

// File: tb/sb_ctrl_test.sv
module sb_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] in_cls;
  logic [4:0] in_dst, in_sa, in_sb;
  logic [4:0] exec_done;
  logic       issue_ok;
  logic [2:0] issue_unit;
  logic [4:0] rd_grant, wr_grant;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sb_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_sa(in_sa), .in_sb(in_sb), .exec_done(exec_done),
    .issue_ok(issue_ok), .issue_unit(issue_unit),
    .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  // Row: valid, class, dst, srcA, srcB, exec_done, exp issue, exp rd, exp wr.
  // Classes (R9): 0 mul, 1 add, 2 div, 3 int. Units: 0,1 mul, 2 add, 3 div, 4 int.
  localparam logic [33:0] VEC [NV] = '{
    {1'b1,2'd3,5'd1, 5'd2, 5'd3, 5'b00000,1'b1,5'b00000,5'b00000}, // 0 int r1 <- r2,r3
    {1'b1,2'd1,5'd4, 5'd1, 5'd5, 5'b00000,1'b1,5'b10000,5'b00000}, // 1 add waits on r1
    {1'b1,2'd3,5'd6, 5'd0, 5'd0, 5'b00001,1'b0,5'b00000,5'b00000}, // 2 R2 int busy; R5 done on idle u0
    {1'b1,2'd3,5'd6, 5'd0, 5'd0, 5'b10000,1'b0,5'b00000,5'b00000}, // 3 R5 u0 must not write
    {1'b1,2'd3,5'd6, 5'd0, 5'd0, 5'b00000,1'b0,5'b00000,5'b10000}, // 4 int writes r1
    {1'b1,2'd3,5'd6, 5'd0, 5'd0, 5'b00000,1'b1,5'b00100,5'b00000}, // 5 R7 add woken; R2 int free
    {1'b1,2'd0,5'd4, 5'd7, 5'd8, 5'b00000,1'b0,5'b10000,5'b00000}, // 6 R2 WAW on r4
    {1'b1,2'd0,5'd4, 5'd7, 5'd8, 5'b00100,1'b0,5'b00000,5'b00000}, // 7
    {1'b1,2'd0,5'd4, 5'd7, 5'd8, 5'b00000,1'b0,5'b00000,5'b00100}, // 8
    {1'b1,2'd0,5'd4, 5'd7, 5'd8, 5'b00000,1'b1,5'b00000,5'b00000}, // 9 mul -> u0
    {1'b1,2'd0,5'd9, 5'd4, 5'd10,5'b00000,1'b1,5'b00001,5'b00000}, // 10 mul -> u1, waits r4
    {1'b1,2'd2,5'd12,5'd9, 5'd11,5'b00000,1'b1,5'b00000,5'b00000}, // 11 div waits r9, holds r11
    {1'b1,2'd1,5'd11,5'd0, 5'd0, 5'b00000,1'b1,5'b00000,5'b00000}, // 12 add targets r11
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b00001,1'b0,5'b00100,5'b00000}, // 13
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b00100,1'b0,5'b00000,5'b00001}, // 14
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b00000,1'b0,5'b00010,5'b00000}, // 15 R6 add blocked
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b10010,1'b0,5'b00000,5'b00000}, // 16 R6
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b00000,1'b0,5'b00000,5'b00010}, // 17 R4 u1 beats u4
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b00000,1'b0,5'b01000,5'b10000}, // 18 R6 div reads
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b00000,1'b0,5'b00000,5'b00100}, // 19 R6 add released
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b01000,1'b0,5'b00000,5'b00000}, // 20
    {1'b1,2'd0,5'd13,5'd12,5'd0, 5'b00000,1'b1,5'b00000,5'b01000}, // 21 R7 issue during wb of r12
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b00000,1'b0,5'b00001,5'b00000}, // 22 R7 ready at once
    {1'b0,2'd0,5'd0, 5'd0, 5'd0, 5'b00000,1'b0,5'b00000,5'b00000}  // 23
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b, input logic [4:0] dn);
    in_valid  = v;
    in_cls    = c;
    in_dst    = d;
    in_sa     = a;
    in_sb     = b;
    exec_done = dn;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    do_reset();

    // R8: reset state, nothing granted.
    #1;
    chk("R8", "issue_ok", int'(issue_ok), 0);
    chk("R8", "rd_grant", int'(rd_grant), 0);
    chk("R8", "wr_grant", int'(wr_grant), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][33], VEC[i][32:31], VEC[i][30:26], VEC[i][25:21],
            VEC[i][20:16], VEC[i][15:11]);
      #1;
      chk("R1", $sformatf("row %0d issue_ok", i), int'(issue_ok), int'(VEC[i][10]));
      chk("R3", $sformatf("row %0d rd_grant", i), int'(rd_grant), int'(VEC[i][9:5]));
      chk("R6", $sformatf("row %0d wr_grant", i), int'(wr_grant), int'(VEC[i][4:0]));
      if (i == 9)  chk("R9", "row 9 unit",  int'(issue_unit), 0);
      if (i == 10) chk("R1", "row 10 unit", int'(issue_unit), 1);
      if (i == 12) chk("R9", "row 12 unit", int'(issue_unit), 2);
    end

    // R1: u0 busy with r13, next multiply goes to u1.
    @(negedge clk);
    drive(1'b1, 2'd0, 5'd15, 5'd0, 5'd0, 5'd0);
    #1;
    chk("R1", "second mul ok", int'(issue_ok), 1);
    chk("R1", "second mul unit", int'(issue_unit), 1);

    // R8: reset mid-work clears the r13 entry and busy units.
    do_reset();
    @(negedge clk);
    drive(1'b1, 2'd0, 5'd13, 5'd0, 5'd0, 5'd0);
    #1;
    chk("R8", "issue after reset", int'(issue_ok), 1);
    chk("R8", "unit after reset", int'(issue_unit), 0);
    @(negedge clk);
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    #1;
    chk("R3", "read after reset", int'(rd_grant), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule